// File: doc/BRIEF.md
# Stable Binary Split Radix Sorter

This block sorts a small set of unsigned keys into nondecreasing order. Each key carries a payload tag that travels with it. Software-side logic first writes the elements one at a time through a load port, then pulses a start input. The block then makes one pass per key bit, starting with the least significant bit. In each pass the elements whose current bit is zero go to the front of a second buffer, and those whose bit is one follow them. Within each group, elements keep the order they had before the pass, so the whole sort is stable.

Two storage buffers alternate roles. Each pass reads from the current source buffer and scatters into the other one, and the roles swap when the pass ends. Each pass takes one cycle to count every zero in the source buffer. It then takes one cycle per element to scatter, using a running zero count and a running one count. The read port always shows the current source buffer. After the final pass that is the sorted result, and before a sort it is the loaded data.

Top module: `radix_split_sorter`

## Requirements
- R1: A sort runs exactly KEY_W passes. Pass p splits on key bit p, so bit 0 is used first and the most significant bit last.
- R2: In a pass, an element whose current bit is 0 is placed at index z, where z is the number of earlier zero-bit elements in the source buffer. An element whose bit is 1 is placed at Z + o, where Z is the total count of zero-bit elements and o is the number of earlier one-bit elements.
- R3: After a sort, keys read at indices 0..N-1 are nondecreasing, and elements with equal keys keep their relative input order (their tags stay in input order).
- R4: readKey/readTag combinationally return the entry at readIdx of the current source buffer. That buffer changes only at the end of a pass, when the buffers swap.
- R5: busy rises in the cycle after an idle start is sampled and stays high for exactly KEY_W*(N+1) cycles.
- R6: done is a single-cycle pulse, asserted in the first cycle in which busy is low again after a sort.
- R7: While idle, loadValid writes loadKey/loadTag to entry loadIdx of the current source buffer. While busy, loadValid has no effect.
- R8: A start pulse sampled while busy is ignored and does not lengthen or restart the sort.
- R9: Inputs that are all zeros, all ones (every key bit set) or all equal come out in their input order.
- R10: During and right after reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Write one element (accepted only while idle) |
| loadIdx | input | IDX_W | Entry index to write |
| loadKey | input | KEY_W | Key to write |
| loadTag | input | TAG_W | Payload tag to write |
| start | input | 1 | Begin a sort (accepted only while idle) |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle pulse when a sort ends |
| readIdx | input | IDX_W | Entry index to read |
| readKey | output | KEY_W | Key at readIdx of the current source buffer |
| readTag | output | TAG_W | Tag at readIdx of the current source buffer |

## Verification
Several properties are checked on every cycle. The busy window must last exactly KEY_W*(N+1) cycles and must begin the cycle after an idle start. done must be a lone pulse, and every finished sort must contain exactly KEY_W buffer swaps. The read port must not change in the middle of a pass. The correctness of each pass's destinations cannot be checked that way, and neither can stability, the ignoring of loads during a sort, or the all-zero, all-one and all-equal cases. Those depend on data, so only the bench scenarios can show them. The bench's behavioural model tracks the buffer contents pass by pass and compares the read port against them every cycle. Each bench tag holds the element's input index, so any loss of order shows up directly.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_COUNT   = 2'd1,
    S_SCATTER = 2'd2
  } sortState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOk;      // idle: external loads allowed
    logic latchTotal;  // latch zero total, clear running counts
    logic writeEn;     // scatter one element this cycle
    logic swap;        // last element of a pass: buffers swap roles
  } ctlStrobe_t;

endpackage

// File: rtl/rss_control.sv
module rss_control
  import rss_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 4,
  parameter int IDX_W = $clog2(N),
  parameter int BIT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctlStrobe_t       ctl,
  output logic [BIT_W-1:0] bitSel,
  output logic [IDX_W-1:0] elemIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_ELEM = IDX_W'(N - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(KEY_W - 1);

  sortState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitSel  <= '0;
      elemIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_COUNT;
            bitSel <= '0;
          end
        end
        S_COUNT: begin
          elemIdx <= '0;
          state   <= S_SCATTER;
        end
        S_SCATTER: begin
          if (elemIdx == LAST_ELEM) begin
            if (bitSel == LAST_BIT) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              bitSel <= bitSel + 1'b1;
              state  <= S_COUNT;
            end
          end else begin
            elemIdx <= elemIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadOk     = (state == S_IDLE);
    ctl.latchTotal = (state == S_COUNT);
    ctl.writeEn    = (state == S_SCATTER);
    ctl.swap       = (state == S_SCATTER) && (elemIdx == LAST_ELEM);
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/rss_datapath.sv
module rss_datapath
  import rss_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 4,
  parameter int TAG_W = 3,
  parameter int IDX_W = $clog2(N),
  parameter int BIT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [BIT_W-1:0] bitSel,
  input  logic [IDX_W-1:0] elemIdx,
  input  logic             loadValid,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [KEY_W-1:0] loadKey,
  input  logic [TAG_W-1:0] loadTag,
  input  logic [IDX_W-1:0] readIdx,
  output logic [KEY_W-1:0] readKey,
  output logic [TAG_W-1:0] readTag
);

  localparam int CNT_W = $clog2(N + 1);

  logic [KEY_W-1:0] keyMem [2][N];
  logic [TAG_W-1:0] tagMem [2][N];

  logic             srcSel;     // buffer holding the current source data
  logic [CNT_W-1:0] zeroTotal;  // zero-bit elements in this pass
  logic [CNT_W-1:0] zeroCnt;    // zero-bit elements already scattered
  logic [CNT_W-1:0] oneCnt;     // one-bit elements already scattered
  logic [CNT_W-1:0] zeroSum;
  logic [KEY_W-1:0] curKey;
  logic [TAG_W-1:0] curTag;
  logic             curBit;
  logic [CNT_W-1:0] destWide;
  logic [IDX_W-1:0] destIdx;

  // Count zero bits across the whole source buffer in one cycle
  always_comb begin
    zeroSum = '0;
    for (int i = 0; i < N; i++) begin
      zeroSum = zeroSum + CNT_W'(!keyMem[srcSel][i][bitSel]);
    end
  end

  assign curKey   = keyMem[srcSel][elemIdx];
  assign curTag   = tagMem[srcSel][elemIdx];
  assign curBit   = curKey[bitSel];
  assign destWide = curBit ? (zeroTotal + oneCnt) : zeroCnt;
  assign destIdx  = destWide[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel    <= 1'b0;
      zeroTotal <= '0;
      zeroCnt   <= '0;
      oneCnt    <= '0;
    end else begin
      if (ctl.latchTotal) begin
        zeroTotal <= zeroSum;
        zeroCnt   <= '0;
        oneCnt    <= '0;
      end else if (ctl.writeEn) begin
        if (curBit) oneCnt  <= oneCnt + 1'b1;
        else        zeroCnt <= zeroCnt + 1'b1;
      end
      if (ctl.swap) srcSel <= ~srcSel;
    end
  end

  // Storage: loads go to the source buffer, scatters to the other one
  always_ff @(posedge clk) begin
    if (ctl.loadOk && loadValid) begin
      keyMem[srcSel][loadIdx] <= loadKey;
      tagMem[srcSel][loadIdx] <= loadTag;
    end else if (ctl.writeEn) begin
      keyMem[~srcSel][destIdx] <= curKey;
      tagMem[~srcSel][destIdx] <= curTag;
    end
  end

  assign readKey = keyMem[srcSel][readIdx];
  assign readTag = tagMem[srcSel][readIdx];

endmodule

// File: rtl/radix_split_sorter.sv
module radix_split_sorter
  import rss_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 4,
  parameter int TAG_W = 3,
  localparam int IDX_W = $clog2(N),
  localparam int BIT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [KEY_W-1:0] loadKey,
  input  logic [TAG_W-1:0] loadTag,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [IDX_W-1:0] readIdx,
  output logic [KEY_W-1:0] readKey,
  output logic [TAG_W-1:0] readTag
);

  ctlStrobe_t       ctl;
  logic [BIT_W-1:0] bitSel;
  logic [IDX_W-1:0] elemIdx;

  rss_control #(.N(N), .KEY_W(KEY_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl),
    .bitSel(bitSel), .elemIdx(elemIdx), .busy(busy), .done(done)
  );

  rss_datapath #(.N(N), .KEY_W(KEY_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitSel(bitSel), .elemIdx(elemIdx),
    .loadValid(loadValid), .loadIdx(loadIdx), .loadKey(loadKey), .loadTag(loadTag),
    .readIdx(readIdx), .readKey(readKey), .readTag(readTag)
  );

endmodule

// File: rtl/rss_checker.sv
module rss_checker
  import rss_pkg::*;
#(
  parameter int N     = 8,
  parameter int KEY_W = 4,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input ctlStrobe_t       ctl,
  input logic [IDX_W-1:0] readIdx,
  input logic [KEY_W-1:0] readKey
);

  localparam int RUN_LEN = KEY_W * (N + 1);

  int runCnt;
  int swapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= 0;
      swapCnt <= 0;
    end else begin
      runCnt  <= busy ? runCnt + 1 : 0;
      swapCnt <= busy ? swapCnt + int'(ctl.swap) : 0;
    end
  end

  // R5: an idle start opens the busy window on the next cycle
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R5 / R8: the busy window has a fixed length, late starts do not stretch it
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt == RUN_LEN));

  // R6: done is a lone pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: each finished sort made exactly one buffer swap per key bit
  a_r1_pass_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (swapCnt == KEY_W));

  // R4: the read port shows a stable buffer inside a pass
  a_r4_stable_source: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.swap) |=> (!$stable(readIdx) || $stable(readKey)));

endmodule

bind radix_split_sorter rss_checker #(.N(N), .KEY_W(KEY_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .ctl(ctl), .readIdx(readIdx), .readKey(readKey)
);

// File: tb/tb_radix_split_sorter.sv
module tb_radix_split_sorter;

  localparam int N       = 8;
  localparam int KEY_W   = 4;
  localparam int TAG_W   = 3;
  localparam int IDX_W   = $clog2(N);
  localparam int RUN_LEN = KEY_W * (N + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             loadValid = 1'b0;
  logic [IDX_W-1:0] loadIdx = '0;
  logic [KEY_W-1:0] loadKey = '0;
  logic [TAG_W-1:0] loadTag = '0;
  logic             start = 1'b0;
  logic             busy, done;
  logic [IDX_W-1:0] readIdx = '0;
  logic [KEY_W-1:0] readKey;
  logic [TAG_W-1:0] readTag;

  always #2 clk = ~clk;  // 250 MHz

  radix_split_sorter #(.N(N), .KEY_W(KEY_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIdx(loadIdx),
    .loadKey(loadKey), .loadTag(loadTag), .start(start), .busy(busy),
    .done(done), .readIdx(readIdx), .readKey(readKey), .readTag(readTag)
  );

  int    checks = 0;
  int    errors = 0;
  string ctx = "";
  string refTag = "R3";

  // Behavioural reference model
  int  mKey [N];
  int  mTag [N];
  int  rKey [N];
  int  rTag [N];
  bit  mBusy = 0, mDone = 0;
  int  mCnt = 0;
  bit  haveData = 0;
  bit  refValid = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic splitPass(input int bitPos);
    int zq[$];
    int oq[$];
    int nk [N];
    int nt [N];
    for (int i = 0; i < N; i++) begin
      if ((mKey[i] >> bitPos) & 1) oq.push_back(i);
      else zq.push_back(i);
    end
    for (int i = 0; i < zq.size(); i++) begin
      nk[i] = mKey[zq[i]]; nt[i] = mTag[zq[i]];
    end
    for (int i = 0; i < oq.size(); i++) begin
      nk[zq.size() + i] = mKey[oq[i]]; nt[zq.size() + i] = mTag[oq[i]];
    end
    mKey = nk;
    mTag = nt;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (loadValid) begin
          mKey[loadIdx] = loadKey;
          mTag[loadIdx] = loadTag;
        end
        if (start) begin
          mBusy = 1; mCnt = 0;
        end
      end else begin
        mCnt++;
        if (mCnt % (N + 1) == 0) begin
          splitPass(mCnt / (N + 1) - 1);
          if (mCnt == RUN_LEN) begin
            mBusy = 0; mDone = 1;
          end
        end
      end
    end
  end

  // Read index sweeps all entries continuously
  always @(posedge clk) begin
    #1 readIdx = IDX_W'((int'(readIdx) + 1) % N);
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == mBusy, {"R5 busy ", ctx}, busy, mBusy);
      chk(done == mDone, {"R6 done ", ctx}, done, mDone);
      if (haveData) begin
        chk(int'(readKey) == mKey[readIdx], {"R1/R2/R4 key ", ctx}, readKey, mKey[readIdx]);
        chk(int'(readTag) == mTag[readIdx], {"R1/R2/R4 tag ", ctx}, readTag, mTag[readIdx]);
      end
      if (refValid && !mBusy) begin
        chk(int'(readKey) == rKey[readIdx], {refTag, " sorted key"}, readKey, rKey[readIdx]);
        chk(int'(readTag) == rTag[readIdx], {refTag, " stable tag"}, readTag, rTag[readIdx]);
      end
    end
  end

  task automatic loadAll(input int keys [N]);
    refValid = 0;
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      loadValid = 1; loadIdx = IDX_W'(i); loadKey = KEY_W'(keys[i]); loadTag = TAG_W'(i);
    end
    @(posedge clk); #1;
    loadValid = 0;
    haveData = 1;
    // Independent stable reference: insertion sort by key
    for (int i = 0; i < N; i++) begin rKey[i] = keys[i]; rTag[i] = i; end
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0 && rKey[j-1] > rKey[j]; j--) begin
        int tk = rKey[j]; int tt = rTag[j];
        rKey[j] = rKey[j-1]; rTag[j] = rTag[j-1];
        rKey[j-1] = tk; rTag[j-1] = tt;
      end
    end
  endtask

  task automatic runSort(input bit disturb);
    @(posedge clk); #1;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (disturb) begin
      repeat (5) @(posedge clk);
      #1;
      ctx = "R8 late start";
      start = 1;                      // R8: ignored while busy
      @(posedge clk); #1;
      start = 0;
      ctx = "R7 load while busy";
      loadValid = 1; loadIdx = '0; loadKey = '1; loadTag = '1;  // R7: ignored
      @(posedge clk); #1;
      loadValid = 0; loadIdx = 3;
      @(posedge clk); #1;
      loadValid = 1;
      @(posedge clk); #1;
      loadValid = 0;
    end
    while (mBusy) @(posedge clk);
    #1;
    refValid = 1;
    repeat (2 * N) @(posedge clk);
    #1;
    ctx = "";
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1;
    // R10: reset state
    chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    chk(done == 1'b0, "R10 done in reset", done, 0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    chk(done == 1'b0, "R10 done after reset", done, 0);

    begin
      int k [N] = '{3, 1, 3, 0, 1, 3, 2, 1};  // duplicates: R3 stability
      refTag = "R3"; ctx = "dup";
      loadAll(k); runSort(0);
    end
    begin
      int k [N];
      for (int i = 0; i < N; i++) k[i] = (i * 5 + 3) % (1 << KEY_W);
      ctx = "mixed"; loadAll(k); runSort(1);   // with R7/R8 disturbance
    end
    begin
      int k [N];
      for (int i = 0; i < N; i++) k[i] = (1 << KEY_W) - 1 - 2 * i;
      ctx = "reverse"; loadAll(k); runSort(0);
    end
    begin
      int k [N];
      refTag = "R9";
      for (int i = 0; i < N; i++) k[i] = 0;
      ctx = "R9 zeros"; loadAll(k); runSort(0);
      for (int i = 0; i < N; i++) k[i] = (1 << KEY_W) - 1;
      ctx = "R9 ones"; loadAll(k); runSort(0);
      for (int i = 0; i < N; i++) k[i] = 5;
      ctx = "R9 equal"; loadAll(k); runSort(0);
    end
    begin
      int k [N] = '{9, 2, 9, 14, 2, 0, 14, 7};
      refTag = "R3"; ctx = "resort";
      loadAll(k); runSort(0);
      runSort(0);  // sorting a sorted set keeps it unchanged
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule